// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the programming port of a pixel readout chip that shares a serial control bus with the other chips of its module. While the shift-enable line is high, it samples one bit of serial input per clock and assembles a 13-bit command header: a 5-bit target chip ID, a 5-bit register number and a 3-bit opcode. A chip acts on a header when the ID equals its strapped ID or equals the all-ones wildcard. The opcode either writes new contents, forces every bit to one or to zero, restores the parameter default, or reads the register back on the serial output.

The register bank mixes widths: eight 8-bit threshold/bias bytes, a 2-bit output-line count, two 1-bit run controls, two per-pixel arrays (pixel disable and test-charge enable) with one bit per pixel, and two zero-width addresses that only emit a one-cycle reset pulse. Each shift-enable window carries exactly one command. Bits that follow a completed or ignored command are discarded until shift-enable drops, and dropping it abandons any unfinished command. The serial port is a plain bit stream paced by the bus master: there is no valid/ready handshake and no back-pressure, because the block accepts a bit on every clock in which shift-enable is high.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every register output holds its parameter default, `sdo` is 0 and both pulse outputs are 0.
- R2: The header is sent MSB first as {chip ID[12:8], register[7:3], opcode[2:0]}. The opcode codes are 1 write, 2 set-all-ones, 3 clear-all-zeros, 4 restore-default and 5 read. Codes 0, 6 and 7 change nothing, and the block drives at most one command strobe per shift window.
- R3: A header is accepted only when its ID equals `chip_id` or is 5'b11111. Any other ID leaves every output unchanged.
- R4: A write takes exactly W further bits, MSB first, where W is the width of the addressed register, and commits them on the edge that samples the last bit. The map is: 0–7 bytes (byte k on `thr_o[8k+7:8k]`), 8 line count (2 bits), 9 send enable, 10 reject hits, 11 pixel-disable array, 12 test-inject array.
- R5: Set and clear force all bits of the addressed register to 1 or to 0 on the edge that samples the last header bit.
- R6: Restore-default reloads the addressed register's parameter value on that same edge.
- R7: A non-broadcast read shows the register MSB on `sdo` right after the last header edge and the next bit after each further shifting edge. `sdo` is 0 after the last bit and whenever shift-enable is low.
- R8: A read carrying the wildcard ID keeps `sdo` at 0 and changes no register.
- R9: Any valid opcode on register 13 or 14 raises `core_rst_o` or `readout_rst_o` respectively for exactly the one cycle after the last header edge, and consumes no data bits.
- R10: A header naming register 15–31 changes nothing, and the bits after it are ignored until shift-enable drops.
- R11: Dropping shift-enable before a header or write is complete discards the partial command. The next window starts a fresh header.
- R12: Pixel bit index is column×ROWS+row. The first write data bit lands on the highest index, and a read returns the highest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; one serial bit per rising edge while enabled |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_id | input | 5 | Strapped chip address |
| shift_en | input | 1 | Shift enable; high frames one command |
| sdi | input | 1 | Serial command and data input |
| sdo | output | 1 | Serial read-back output |
| thr_o | output | 64 | Eight threshold/bias bytes |
| lines_o | output | 2 | Active output line count code |
| send_o | output | 1 | Send-data control |
| reject_o | output | 1 | Reject-hits control |
| kill_o | output | COLS×ROWS | Per-pixel disable bits |
| inject_o | output | COLS×ROWS | Per-pixel test-charge enable bits |
| core_rst_o | output | 1 | One-cycle core reset pulse |
| readout_rst_o | output | 1 | One-cycle readout reset pulse |

## Verification
The assertions assume that each shift-enable window carries a single command and that `sdi` holds a defined value on every enabled edge. They also assume that `chip_id` stays constant during a window. The bench keeps to this: it drives every frame from one task that lowers shift-enable for at least one cycle between frames, holds the strap at a fixed value, and draws random IDs, register numbers, opcodes, data and abort points only inside well-formed windows. Directed frames cover the wildcard, a foreign ID, unknown registers, illegal opcodes, the zero-width pulse registers, and aborts in the header and in the data.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int HDR_W = 13;
  localparam int NBYTE = 8;
  localparam logic [4:0] ID_ALL = 5'b11111;

  localparam logic [4:0] A_LINES  = 5'd8;
  localparam logic [4:0] A_SEND   = 5'd9;
  localparam logic [4:0] A_REJECT = 5'd10;
  localparam logic [4:0] A_KILL   = 5'd11;
  localparam logic [4:0] A_INJECT = 5'd12;
  localparam logic [4:0] A_PCORE  = 5'd13;
  localparam logic [4:0] A_PREAD  = 5'd14;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SET   = 3'd2,
    OP_CLEAR = 3'd3,
    OP_DEF   = 3'd4,
    OP_READ  = 3'd5
  } op_e;

  function automatic int reg_width(input logic [4:0] a, input int npix);
    if (int'(a) < NBYTE) return 8;
    case (a)
      A_LINES:            return 2;
      A_SEND, A_REJECT:   return 1;
      A_KILL, A_INJECT:   return npix;
      default:            return 0;
    endcase
  endfunction

  function automatic logic reg_known(input logic [4:0] a);
    return a <= A_PREAD;
  endfunction

  function automatic logic op_valid(input logic [2:0] o);
    return (o >= 3'd1) && (o <= 3'd5);
  endfunction
endpackage

// File: rtl/scp_field.sv
module scp_field #(
  parameter int W = 8,
  parameter logic [W-1:0] DEF = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic         def_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= DEF;
    else if (wr_en)  q <= wr_val;
    else if (set_en) q <= '1;
    else if (clr_en) q <= '0;
    else if (def_en) q <= DEF;
  end

  assert_set_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (q == '1));
  assert_clear_zeros_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (q == '0));
  assert_default_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    def_en |=> (q == DEF));
endmodule

// File: rtl/scp_parser.sv
module scp_parser import scp_pkg::*; #(
  parameter int NPIX = 2816,
  parameter int MAXW = 2816
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            sdi,
  input  logic [4:0]      chip_id,
  output logic            hdr_fire,
  output logic [2:0]      hdr_op,
  output logic [4:0]      hdr_addr,
  output logic            hdr_bcast,
  output logic            wr_fire,
  output logic [4:0]      wr_addr,
  output logic [MAXW-1:0] wr_data
);
  localparam int CW = $clog2(MAXW + HDR_W + 1) + 1;

  typedef enum logic [1:0] {S_HDR, S_DATA, S_DRAIN} st_e;

  st_e               st;
  logic [HDR_W-2:0]  hdr_q;
  logic [CW-1:0]     cnt, dlen, wd;
  logic [4:0]        addr_q;
  logic [MAXW-1:0]   dbuf;
  logic [HDR_W-1:0]  full;
  logic              hdr_done, id_ok, accept, needs_data;

  always_comb begin
    full       = {hdr_q, sdi};
    hdr_addr   = full[7:3];
    hdr_op     = full[2:0];
    hdr_bcast  = (full[12:8] == ID_ALL);
    id_ok      = hdr_bcast || (full[12:8] == chip_id);
    wd         = CW'(reg_width(hdr_addr, NPIX));
    accept     = id_ok && reg_known(hdr_addr) && op_valid(hdr_op);
    hdr_done   = shift_en && (st == S_HDR) && (cnt == CW'(HDR_W - 1));
    needs_data = (hdr_op == OP_WRITE) && (wd != '0);
    hdr_fire   = hdr_done && accept && !needs_data;
    wr_fire    = shift_en && (st == S_DATA) && (cnt == dlen - 1'b1);
    wr_addr    = addr_q;
    wr_data    = {dbuf[MAXW-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_HDR;
      hdr_q  <= '0;
      cnt    <= '0;
      dlen   <= '0;
      addr_q <= '0;
      dbuf   <= '0;
    end else if (!shift_en) begin
      st  <= S_HDR;
      cnt <= '0;
    end else begin
      case (st)
        S_HDR: begin
          hdr_q <= full[HDR_W-2:0];
          if (hdr_done) begin
            cnt <= '0;
            if (accept && needs_data) begin
              st     <= S_DATA;
              dlen   <= wd;
              addr_q <= hdr_addr;
            end else begin
              st <= S_DRAIN;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          dbuf <= wr_data;
          if (wr_fire) st <= S_DRAIN;
          else         cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_fire, wr_fire}));
  assert_abort_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> (!wr_fire && !hdr_fire));
  assert_one_cmd_per_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_fire || wr_fire) |=> !(hdr_fire || wr_fire));
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank import scp_pkg::*; #(
  parameter int NPIX = 2816,
  parameter int MAXW = 2816,
  parameter logic [NBYTE*8-1:0] BYTE_DEF = '0,
  parameter logic [1:0] LINES_DEF = 2'd0,
  parameter logic SEND_DEF = 1'b0,
  parameter logic REJECT_DEF = 1'b0,
  parameter logic [NPIX-1:0] KILL_DEF = '0,
  parameter logic [NPIX-1:0] INJECT_DEF = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_fire,
  input  logic [2:0]        hdr_op,
  input  logic [4:0]        hdr_addr,
  input  logic              wr_fire,
  input  logic [4:0]        wr_addr,
  input  logic [MAXW-1:0]   wr_data,
  output logic [NBYTE*8-1:0] thr_o,
  output logic [1:0]        lines_o,
  output logic              send_o,
  output logic              reject_o,
  output logic [NPIX-1:0]   kill_o,
  output logic [NPIX-1:0]   inject_o,
  output logic              core_rst_o,
  output logic              readout_rst_o,
  output logic [MAXW-1:0]   rd_value
);
  localparam int NFIELD = NBYTE + 5;

  logic [NFIELD-1:0] wr_en, set_en, clr_en, def_en;

  for (genvar k = 0; k < NFIELD; k++) begin : g_en
    localparam logic [4:0] AK = 5'(k);
    assign wr_en[k]  = wr_fire && (wr_addr == AK);
    assign set_en[k] = hdr_fire && (hdr_addr == AK) && (hdr_op == OP_SET);
    assign clr_en[k] = hdr_fire && (hdr_addr == AK) && (hdr_op == OP_CLEAR);
    assign def_en[k] = hdr_fire && (hdr_addr == AK) && (hdr_op == OP_DEF);
  end

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    scp_field #(.W(8), .DEF(BYTE_DEF[g*8 +: 8])) u_byte (
      .clk, .rst_n, .wr_en(wr_en[g]), .set_en(set_en[g]), .clr_en(clr_en[g]),
      .def_en(def_en[g]), .wr_val(wr_data[7:0]), .q(thr_o[g*8 +: 8]));
  end

  scp_field #(.W(2), .DEF(LINES_DEF)) u_lines (
    .clk, .rst_n, .wr_en(wr_en[A_LINES]), .set_en(set_en[A_LINES]),
    .clr_en(clr_en[A_LINES]), .def_en(def_en[A_LINES]),
    .wr_val(wr_data[1:0]), .q(lines_o));
  scp_field #(.W(1), .DEF(SEND_DEF)) u_send (
    .clk, .rst_n, .wr_en(wr_en[A_SEND]), .set_en(set_en[A_SEND]),
    .clr_en(clr_en[A_SEND]), .def_en(def_en[A_SEND]),
    .wr_val(wr_data[0]), .q(send_o));
  scp_field #(.W(1), .DEF(REJECT_DEF)) u_reject (
    .clk, .rst_n, .wr_en(wr_en[A_REJECT]), .set_en(set_en[A_REJECT]),
    .clr_en(clr_en[A_REJECT]), .def_en(def_en[A_REJECT]),
    .wr_val(wr_data[0]), .q(reject_o));
  scp_field #(.W(NPIX), .DEF(KILL_DEF)) u_kill (
    .clk, .rst_n, .wr_en(wr_en[A_KILL]), .set_en(set_en[A_KILL]),
    .clr_en(clr_en[A_KILL]), .def_en(def_en[A_KILL]),
    .wr_val(wr_data[NPIX-1:0]), .q(kill_o));
  scp_field #(.W(NPIX), .DEF(INJECT_DEF)) u_inject (
    .clk, .rst_n, .wr_en(wr_en[A_INJECT]), .set_en(set_en[A_INJECT]),
    .clr_en(clr_en[A_INJECT]), .def_en(def_en[A_INJECT]),
    .wr_val(wr_data[NPIX-1:0]), .q(inject_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_rst_o    <= 1'b0;
      readout_rst_o <= 1'b0;
    end else begin
      core_rst_o    <= hdr_fire && (hdr_addr == A_PCORE);
      readout_rst_o <= hdr_fire && (hdr_addr == A_PREAD);
    end
  end

  always_comb begin
    rd_value = '0;
    if (int'(hdr_addr) < NBYTE) rd_value[7:0] = thr_o[hdr_addr*8 +: 8];
    else begin
      case (hdr_addr)
        A_LINES:  rd_value[1:0]      = lines_o;
        A_SEND:   rd_value[0]        = send_o;
        A_REJECT: rd_value[0]        = reject_o;
        A_KILL:   rd_value[NPIX-1:0] = kill_o;
        A_INJECT: rd_value[NPIX-1:0] = inject_o;
        default:  rd_value           = '0;
      endcase
    end
  end

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_o || readout_rst_o) |=> !(core_rst_o || readout_rst_o));
endmodule

// File: rtl/scp_readout.sv
module scp_readout #(
  parameter int MAXW = 2816
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            load,
  input  logic [MAXW-1:0] load_val,
  output logic            sdo
);
  logic [MAXW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh <= '0;
    else if (!shift_en) sh <= '0;
    else if (load)      sh <= load_val;
    else                sh <= {sh[MAXW-2:0], 1'b0};
  end

  assign sdo = sh[MAXW-1];

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> !sdo);
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port import scp_pkg::*; #(
  parameter int PIX_COLS = 22,
  parameter int PIX_ROWS = 128,
  parameter logic [NBYTE*8-1:0] BYTE_DEF = 64'h8080_8080_4040_4040,
  parameter logic [1:0] LINES_DEF = 2'd0,
  parameter logic SEND_DEF = 1'b0,
  parameter logic REJECT_DEF = 1'b0,
  parameter logic [PIX_COLS*PIX_ROWS-1:0] KILL_DEF = '0,
  parameter logic [PIX_COLS*PIX_ROWS-1:0] INJECT_DEF = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [4:0]                   chip_id,
  input  logic                         shift_en,
  input  logic                         sdi,
  output logic                         sdo,
  output logic [NBYTE*8-1:0]           thr_o,
  output logic [1:0]                   lines_o,
  output logic                         send_o,
  output logic                         reject_o,
  output logic [PIX_COLS*PIX_ROWS-1:0] kill_o,
  output logic [PIX_COLS*PIX_ROWS-1:0] inject_o,
  output logic                         core_rst_o,
  output logic                         readout_rst_o
);
  localparam int NPIX = PIX_COLS * PIX_ROWS;
  localparam int MAXW = (NPIX > 8) ? NPIX : 8;

  logic            hdr_fire, hdr_bcast, wr_fire, rd_load;
  logic [2:0]      hdr_op;
  logic [4:0]      hdr_addr, wr_addr;
  logic [MAXW-1:0] wr_data, rd_value, rd_aligned;

  scp_parser #(.NPIX(NPIX), .MAXW(MAXW)) u_parser (
    .clk, .rst_n, .shift_en, .sdi, .chip_id,
    .hdr_fire, .hdr_op, .hdr_addr, .hdr_bcast,
    .wr_fire, .wr_addr, .wr_data);

  scp_regbank #(
    .NPIX(NPIX), .MAXW(MAXW), .BYTE_DEF(BYTE_DEF), .LINES_DEF(LINES_DEF),
    .SEND_DEF(SEND_DEF), .REJECT_DEF(REJECT_DEF),
    .KILL_DEF(KILL_DEF), .INJECT_DEF(INJECT_DEF)
  ) u_bank (
    .clk, .rst_n, .hdr_fire, .hdr_op, .hdr_addr, .wr_fire, .wr_addr, .wr_data,
    .thr_o, .lines_o, .send_o, .reject_o, .kill_o, .inject_o,
    .core_rst_o, .readout_rst_o, .rd_value);

  assign rd_load    = hdr_fire && (hdr_op == OP_READ) && !hdr_bcast;
  assign rd_aligned = rd_value << (MAXW - reg_width(hdr_addr, NPIX));

  scp_readout #(.MAXW(MAXW)) u_out (
    .clk, .rst_n, .shift_en, .load(rd_load), .load_val(rd_aligned), .sdo);

  assert_bcast_read_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_fire && hdr_bcast && (hdr_op == OP_READ)) |=> !sdo);
endmodule

// File: tb/sim_serial_cfg_port.sv
module sim_serial_cfg_port;
  localparam int COLS = 4, ROWS = 8, NPIX = COLS * ROWS;
  localparam logic [4:0] STRAP = 5'd6;
  localparam logic [63:0] BDEF = 64'hA1B2_C3D4_E5F6_0718;
  localparam logic [1:0]  LDEF = 2'd2;
  localparam logic [31:0] KDEF = 32'h0000_FFFF;
  localparam logic [31:0] IDEF = 32'h1234_5678;

  logic clk = 0, rst_n = 0, shift_en = 0, sdi = 0;
  logic sdo, send_o, reject_o, core_rst_o, readout_rst_o;
  logic [63:0] thr_o;
  logic [1:0] lines_o;
  logic [NPIX-1:0] kill_o, inject_o;
  int checks = 0, errs = 0;
  bit done = 0;

  logic [63:0] m_thr;
  logic [1:0]  m_lines;
  logic        m_send, m_rej;
  logic [31:0] m_kill, m_inj;

  always #5 clk = ~clk;

  serial_cfg_port #(.PIX_COLS(COLS), .PIX_ROWS(ROWS), .BYTE_DEF(BDEF),
    .LINES_DEF(LDEF), .SEND_DEF(1'b1), .REJECT_DEF(1'b0),
    .KILL_DEF(KDEF), .INJECT_DEF(IDEF)) u0 (
    .clk, .rst_n, .chip_id(STRAP), .shift_en, .sdi, .sdo, .thr_o, .lines_o,
    .send_o, .reject_o, .kill_o, .inject_o, .core_rst_o, .readout_rst_o);

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int wid(input int a);
    if (a < 8) return 8;
    case (a) 8: return 2; 9, 10: return 1; 11, 12: return NPIX; default: return 0; endcase
  endfunction

  function automatic logic [31:0] mget(input int a);
    if (a < 8) return 32'(m_thr[a*8 +: 8]);
    case (a)
      8: return 32'(m_lines); 9: return 32'(m_send); 10: return 32'(m_rej);
      11: return m_kill; 12: return m_inj; default: return 0;
    endcase
  endfunction

  task automatic mput(input int a, input logic [31:0] v);
    if (a < 8) m_thr[a*8 +: 8] = v[7:0];
    else case (a)
      8: m_lines = v[1:0]; 9: m_send = v[0]; 10: m_rej = v[0];
      11: m_kill = v; 12: m_inj = v; default: ;
    endcase
  endtask

  task automatic mdef(input int a);
    if (a < 8) m_thr[a*8 +: 8] = BDEF[a*8 +: 8];
    else case (a)
      8: m_lines = LDEF; 9: m_send = 1'b1; 10: m_rej = 1'b0;
      11: m_kill = KDEF; 12: m_inj = IDEF; default: ;
    endcase
  endtask

  task automatic cmp_all(input string tag);
    chk(tag, "thr", thr_o, m_thr);
    chk(tag, "lines", 64'(lines_o), 64'(m_lines));
    chk(tag, "send", 64'(send_o), 64'(m_send));
    chk(tag, "reject", 64'(reject_o), 64'(m_rej));
    chk(tag, "kill", 64'(kill_o), 64'(m_kill));
    chk(tag, "inject", 64'(inject_o), 64'(m_inj));
  endtask

  task automatic frame(input logic [4:0] id, input logic [4:0] addr, input logic [2:0] op,
                       input logic [31:0] data, input int abort_at, input string tag);
    logic [12:0] hdr = {id, addr, op};
    bit bc = (id == 5'h1F);
    bit acc = (bc || id == STRAP) && addr <= 5'd14 && op >= 3'd1 && op <= 3'd5;
    int w = wid(int'(addr));
    bit isw = acc && op == 3'd1 && w > 0;
    int nb = 13 + w + 2;
    int sent = (abort_at >= 0 && abort_at < nb) ? abort_at : nb;
    logic [31:0] rv = mget(int'(addr));
    for (int i = 0; i < sent; i++) begin
      logic b, es;
      if (i < 13) b = hdr[12-i];
      else if (isw && i - 13 < w) b = data[w-1-(i-13)];
      else b = 1'($urandom);
      shift_en = 1; sdi = b;
      @(posedge clk); #1;
      es = 0;
      if (acc && op == 3'd5 && !bc && i >= 12 && i - 12 < w) es = rv[w-1-(i-12)];
      chk(tag, "sdo", 64'(sdo), 64'(es));
      chk(tag, "core_rst", 64'(core_rst_o), 64'(acc && addr == 5'd13 && i == 12));
      chk(tag, "readout_rst", 64'(readout_rst_o), 64'(acc && addr == 5'd14 && i == 12));
    end
    if (acc && sent >= 13) begin
      if (isw) begin if (sent >= 13 + w) mput(int'(addr), data); end
      else case (op)
        3'd2: mput(int'(addr), '1);
        3'd3: mput(int'(addr), '0);
        3'd4: mdef(int'(addr));
        default: ;
      endcase
    end
    shift_en = 0; sdi = 0;
    @(posedge clk); #1;
    chk(tag, "sdo idle", 64'(sdo), 64'd0);
    cmp_all(tag);
  endtask

  function automatic string tag_of(input logic [4:0] id, input logic [4:0] a, input logic [2:0] op, input int ab);
    if (ab >= 0) return "R11";
    if (id != STRAP && id != 5'h1F) return "R3";
    if (op == 3'd0 || op > 3'd5) return "R2";
    if (a > 5'd14) return "R10";
    if (a >= 5'd13) return "R9";
    if (op == 3'd5) return (id == 5'h1F) ? "R8" : "R7";
    if (op == 3'd4) return "R6";
    if (op != 3'd1) return "R5";
    return (a == 5'd11 || a == 5'd12) ? "R12" : "R4";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_thr = BDEF; m_lines = LDEF; m_send = 1; m_rej = 0; m_kill = KDEF; m_inj = IDEF;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    cmp_all("R1");
    chk("R1", "sdo", 64'(sdo), 0);
    chk("R1", "pulses", 64'({core_rst_o, readout_rst_o}), 0);
    rst_n = 1;
    @(posedge clk); #1;

    frame(STRAP, 5'd3, 3'd1, 32'h5A, -1, "R4");
    frame(STRAP, 5'd3, 3'd5, 0, -1, "R7");
    frame(5'h1F, 5'd11, 3'd1, 32'h8000_0001, -1, "R12");
    frame(STRAP, 5'd11, 3'd5, 0, -1, "R12");
    frame(5'd9, 5'd0, 3'd1, 32'hFF, -1, "R3");
    frame(STRAP, 5'd8, 3'd2, 0, -1, "R5");
    frame(STRAP, 5'd12, 3'd3, 0, -1, "R5");
    frame(STRAP, 5'd3, 3'd4, 0, -1, "R6");
    frame(STRAP, 5'd11, 3'd4, 0, -1, "R6");
    frame(5'h1F, 5'd3, 3'd5, 0, -1, "R8");
    frame(STRAP, 5'd13, 3'd1, 0, -1, "R9");
    frame(5'h1F, 5'd14, 3'd5, 0, -1, "R9");
    frame(STRAP, 5'd20, 3'd1, 32'hAB, -1, "R10");
    frame(STRAP, 5'd2, 3'd7, 32'hAB, -1, "R2");
    frame(STRAP, 5'd2, 3'd0, 32'hAB, -1, "R2");
    frame(STRAP, 5'd4, 3'd1, 32'h3C, 16, "R11");
    frame(STRAP, 5'd4, 3'd2, 0, 7, "R11");
    frame(STRAP, 5'd9, 3'd1, 32'h0, -1, "R4");
    frame(STRAP, 5'd10, 3'd1, 32'h1, -1, "R4");
    frame(STRAP, 5'd10, 3'd5, 0, -1, "R7");

    for (int n = 0; n < 500; n++) begin
      logic [4:0] id, a;
      logic [2:0] op;
      int ab, r;
      r = int'($urandom % 4);
      if (r < 2) id = STRAP;
      else if (r == 2) id = 5'h1F;
      else begin id = 5'($urandom % 31); if (id == STRAP) id = 5'd0; end
      a  = 5'($urandom % 18);
      op = 3'($urandom);
      ab = ($urandom % 5 == 0) ? int'($urandom % (15 + wid(int'(a)))) : -1;
      frame(id, a, op, $urandom, ab, tag_of(id, a, op, ab));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule